// File: doc/BRIEF.md
# On/Off Cycle-Skipping Gate Sequencer

This block drives the gate of the power switch in a converter that regulates by taking or skipping whole switching cycles. It does not vary the pulse width. A cycle-start input from the oscillator marks each switching period. On the rising edge of that input, the block looks at a synchronised feedback enable level and at two fault flags. From these it decides whether the switch conducts during the period.

When the switch has been turned on, it stays on until one of two things ends the cycle:
- the current-limit comparator reports overcurrent, which is only heeded once a blanking window after turn-on has elapsed; or
- the maximum-duty window from the oscillator closes.

Each period ends with a single-clock status strobe. The strobe reports whether the cycle was skipped, ended by current limit, or ended by the duty-max window.

Top module: `cskip_ctrl`

## Requirements
- R1: While reset is asserted, and in the first clock after it, `gate` and `stat_vld` are 0.
- R2: A cycle start is the first system clock edge that samples `cyc_clk` high after it was low. On that edge, the switch turns on (`gate` reads 1 after the edge) if the synchronised enable is 1, `dmax` is 1, and both fault flags are 0. `en_in` must have been high for two clock edges before the start edge to count as 1.
- R3: If the enable is 0 at a cycle start, `gate` stays 0 for the entire period, even if `en_in` rises later in the period.
- R4: Once `gate` is 1, a change of `en_in` has no effect on `gate` for the rest of that cycle.
- R5: For `BLANK_CYC` clock edges after the turn-on edge, the current-limit input is ignored. With `ilim_in` held high from turn-on, `gate` stays high for exactly `BLANK_CYC`+1 clocks.
- R6: After blanking, if `ilim_in` is high before clock edge A, `gate` is 0 after edge A+2. It then stays 0 until the next cycle start, even if `ilim_in` clears.
- R7: The first edge that samples `dmax` low while `gate` is 1 turns `gate` off. A cycle start with `dmax` low is skipped.
- R8: If `uv_flt` or `ot_flt` is 1 at a cycle start, that cycle is skipped.
- R9: `stat_vld` pulses for one clock at the end of each period, with fields `{stat_taken, stat_ilim, stat_dmax}`. The code is 3'b000 for a skipped cycle (in the clock after the start edge), 3'b110 for a current-limit end, and 3'b101 for a duty-max end. If both ends occur on the same edge, the code is 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_clk | input | 1 | Cycle-start signal from the oscillator, synchronous to clk |
| dmax | input | 1 | Maximum-duty window, high while conduction is allowed |
| en_in | input | 1 | Feedback enable level, asynchronous |
| ilim_in | input | 1 | Current-limit comparator output, asynchronous |
| uv_flt | input | 1 | Supply under-voltage inhibit |
| ot_flt | input | 1 | Over-temperature inhibit |
| gate | output | 1 | Switch gate command |
| stat_vld | output | 1 | One-clock end-of-period status strobe |
| stat_taken | output | 1 | Period conducted |
| stat_ilim | output | 1 | Period ended by current limit |
| stat_dmax | output | 1 | Period ended by duty-max window |

## Verification
`gate` and the skip strobe both appear one clock after the edge that samples the cycle start. A `dmax` drop shows on `gate` one clock later. A current-limit trip shows three clock edges after `ilim_in` rises, because of the two synchroniser flops, and no earlier than `BLANK_CYC`+1 clocks after turn-on. The bench drives inputs on the falling clock edge and counts rising edges from each stimulus to the exact falling edge where the result is due, checking `gate` there. A queue holds the status code expected for each period, and a monitor pops it whenever `stat_vld` is seen.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_ON   = 1'b1
  } cs_state_t;
endpackage

// File: rtl/cskip_sync.sv
module cskip_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cskip_blank.sv
module cskip_blank #(
  parameter int BLANK_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = CW'(BLANK_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R5: a fresh load always opens a blanking window when BLANK_CYC is nonzero
  a_r5_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (load && BLANK_CYC > 0) |=> !done);
endmodule

// File: rtl/cskip_ctrl.sv
module cskip_ctrl
  import cskip_pkg::*;
#(
  parameter int BLANK_CYC   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_clk,
  input  logic dmax,
  input  logic en_in,
  input  logic ilim_in,
  input  logic uv_flt,
  input  logic ot_flt,
  output logic gate,
  output logic stat_vld,
  output logic stat_taken,
  output logic stat_ilim,
  output logic stat_dmax
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] async_in, sync_out;
  logic en_s, ilim_s;
  logic cyc_q;
  logic start_edge, take, turn_on, cut_ilim, cut_end, blank_done;
  cs_state_t state_q, state_d;
  logic vld_d, tak_d, il_d, dm_d;

  assign async_in = {ilim_in, en_in};

  cskip_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );
  assign en_s   = sync_out[0];
  assign ilim_s = sync_out[1];

  cskip_blank #(.BLANK_CYC(BLANK_CYC)) blank_i (
    .clk(clk), .rst_n(rst_n), .load(turn_on), .done(blank_done)
  );

  assign start_edge = cyc_clk & ~cyc_q;
  assign take       = en_s & dmax & ~uv_flt & ~ot_flt;
  assign turn_on    = (state_q == CS_IDLE) & start_edge & take;
  assign cut_ilim   = ilim_s & blank_done;
  assign cut_end    = cut_ilim | ~dmax;

  always_comb begin
    state_d = state_q;
    vld_d   = 1'b0;
    tak_d   = 1'b0;
    il_d    = 1'b0;
    dm_d    = 1'b0;
    case (state_q)
      CS_IDLE: begin
        if (start_edge) begin
          if (take) state_d = CS_ON;
          else      vld_d   = 1'b1;
        end
      end
      CS_ON: begin
        if (cut_end) begin
          state_d = CS_IDLE;
          vld_d   = 1'b1;
          tak_d   = 1'b1;
          il_d    = cut_ilim;
          dm_d    = ~cut_ilim;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      cyc_q      <= 1'b0;
      stat_vld   <= 1'b0;
      stat_taken <= 1'b0;
      stat_ilim  <= 1'b0;
      stat_dmax  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cyc_q      <= cyc_clk;
      stat_vld   <= vld_d;
      stat_taken <= tak_d;
      stat_ilim  <= il_d;
      stat_dmax  <= dm_d;
    end
  end

  assign gate = (state_q == CS_ON);

  // R2: conduction only begins at a detected cycle start
  a_r2_on_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(start_edge));
  // R8: no turn-on while a fault inhibit is active
  a_r8_fault_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(!uv_flt && !ot_flt));
  // R5: within blanking only the duty window may end conduction
  a_r5_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !blank_done && dmax) |=> gate);
  // R7: duty window closing ends conduction on the next edge
  a_r7_dmax_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !dmax) |=> !gate);
  // R9: every turn-off is reported as a taken cycle with one cause
  a_r9_end_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> (stat_vld && stat_taken && $onehot0({stat_ilim, stat_dmax})
                     && (stat_ilim || stat_dmax)));
  // R9: a skipped report carries no cause
  a_r9_skip_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && !stat_taken) |-> (!stat_ilim && !stat_dmax));
endmodule

// File: tb/cskip_ctrl_tb.sv
module cskip_ctrl_tb_top;
  logic clk, rst_n, cyc_clk, dmax, en_in, ilim_in, uv_flt, ot_flt;
  logic gate, stat_vld, stat_taken, stat_ilim, stat_dmax;

  int checks = 0;
  int errs   = 0;
  logic [2:0] expq [$];

  cskip_ctrl #(.BLANK_CYC(6), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_clk(cyc_clk), .dmax(dmax), .en_in(en_in),
    .ilim_in(ilim_in), .uv_flt(uv_flt), .ot_flt(ot_flt), .gate(gate),
    .stat_vld(stat_vld), .stat_taken(stat_taken), .stat_ilim(stat_ilim),
    .stat_dmax(stat_dmax)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_gate(input logic exp, input string tag);
    chk(gate === exp, tag, int'(gate), int'(exp));
  endtask

  task automatic nt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: one-clock cycle-start pulse, returns one negedge later
  task automatic start_cyc(input logic dm, input logic [2:0] exp);
    expq.push_back(exp);
    cyc_clk = 1'b1;
    dmax    = dm;
    @(negedge clk);
    cyc_clk = 1'b0;
  endtask

  // monitor: status strobe scoreboard (R9)
  always @(negedge clk) begin
    if (rst_n && stat_vld) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", int'({stat_taken, stat_ilim, stat_dmax}), -1);
      end else begin
        logic [2:0] e;
        e = expq.pop_front();
        chk({stat_taken, stat_ilim, stat_dmax} === e, "R9 status code",
            int'({stat_taken, stat_ilim, stat_dmax}), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_clk = 1'b0; dmax = 1'b0; en_in = 1'b0;
    ilim_in = 1'b0; uv_flt = 1'b0; ot_flt = 1'b0;
    nt(3);
    chk_gate(1'b0, "R1 gate in reset");
    chk(stat_vld === 1'b0, "R1 stat_vld in reset", int'(stat_vld), 0);
    rst_n = 1'b1;
    nt(1);
    chk_gate(1'b0, "R1 gate after release");
    en_in = 1'b1;
    nt(4);

    // taken cycle, enable drops mid-cycle, duty window ends it
    start_cyc(1'b1, 3'b101);
    chk_gate(1'b1, "R2 turn-on at start");
    en_in = 1'b0;
    nt(3);
    chk_gate(1'b1, "R4 enable drop ignored");
    dmax = 1'b0;
    nt(1);
    chk_gate(1'b0, "R7 dmax cut");
    nt(3);

    // skipped cycle, enable rises mid-cycle
    start_cyc(1'b1, 3'b000);
    chk_gate(1'b0, "R3 skip on low enable");
    en_in = 1'b1;
    nt(4);
    chk_gate(1'b0, "R3 late enable ignored");
    dmax = 1'b0;
    nt(2);

    // current limit held from turn-on: blanking bound
    start_cyc(1'b1, 3'b110);
    ilim_in = 1'b1;
    nt(6);
    chk_gate(1'b1, "R5 blanked");
    nt(1);
    chk_gate(1'b0, "R5 cut after blanking");
    ilim_in = 1'b0;
    nt(3);
    chk_gate(1'b0, "R6 stays off for rest of cycle");
    dmax = 1'b0;
    nt(3);

    // current limit after blanking: latency of three edges
    start_cyc(1'b1, 3'b110);
    nt(9);
    ilim_in = 1'b1;
    nt(2);
    chk_gate(1'b1, "R6 before sync latency");
    nt(1);
    chk_gate(1'b0, "R6 cut after sync");
    ilim_in = 1'b0;
    dmax = 1'b0;
    nt(3);

    // current limit and duty end on the same edge
    start_cyc(1'b1, 3'b110);
    nt(9);
    ilim_in = 1'b1;
    nt(2);
    chk_gate(1'b1, "R9 still on before tie");
    dmax = 1'b0;
    nt(1);
    chk_gate(1'b0, "R9 tie turns off");
    ilim_in = 1'b0;
    nt(3);

    // fault inhibits
    uv_flt = 1'b1;
    start_cyc(1'b1, 3'b000);
    chk_gate(1'b0, "R8 under-voltage skip");
    nt(3);
    chk_gate(1'b0, "R8 under-voltage whole cycle");
    uv_flt = 1'b0;
    dmax = 1'b0;
    nt(2);
    ot_flt = 1'b1;
    start_cyc(1'b1, 3'b000);
    chk_gate(1'b0, "R8 over-temperature skip");
    ot_flt = 1'b0;
    dmax = 1'b0;
    nt(2);

    // start with duty window closed
    start_cyc(1'b0, 3'b000);
    chk_gate(1'b0, "R7 dmax low at start");
    nt(2);

    // synchroniser latency on enable
    en_in = 1'b0;
    nt(3);
    en_in = 1'b1;
    nt(1);
    start_cyc(1'b1, 3'b000);
    chk_gate(1'b0, "R2 enable too recent");
    dmax = 1'b0;
    nt(2);
    start_cyc(1'b1, 3'b101);
    chk_gate(1'b1, "R2 enable settled");
    dmax = 1'b0;
    nt(1);
    chk_gate(1'b0, "R7 dmax cut inside blanking");
    nt(3);

    chk(expq.size() == 0, "R9 all strobes seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule